// File: doc/BRIEF.md
# Folded Add-Shift Accumulator Slice Array

This block is the accumulator half of a pipelined Booth multiplier. It is built as a row of one-bit slices. Commands enter at the rightmost (least significant) slice and travel left by one slice per executed step. Accumulator bits travel right. A slice executes a command once it holds both the command and the data bit from its left neighbour. It then sends the new bit to the right, so every command also shifts the accumulator by one place. It sends the command, together with the carry it produced, on to the left. Because of this, no separate shifter exists. A sum produced in one slice is consumed by the next arithmetic step in the neighbouring slice on the following cycle.

The multiplicand is a fixed bus that stays stable while commands are in flight. A sequencer outside the block issues one command at most every other cycle on the command port. The bit leaving the least significant slice is the block's data output. The command leaving the most significant slice, with its final carry, appears on the left exit port.

Viewed as a word, each command acts on the accumulator Y (WIDTH bits, two's complement). Let X be Y shifted right arithmetically by one, with the sign bit copied. The new Y is 0, X, X+B, X+2B, X-B or X-2B, taken modulo 2^WIDTH.

Top module: `fold_accum_array`

## Requirements
- R1: While reset is high and in the cycle after it, `dout_valid` and `left_valid` are 0. The accumulator starts at zero, so a shift issued first returns `dout`=0.
- R2: `in_cmd` is one-hot with bit 0 = initialize, bit 1 = add, bit 2 = add 2x, bit 3 = subtract, bit 4 = subtract 2x, bit 5 = shift. A word with `in_valid`=1 and zero set bits, or several set bits, is ignored. No output appears and the accumulator is left unchanged.
- R3: Initialize clears every accumulator bit and produces a carry of 0, so `dout`=0.
- R4: Shift sets Y to X (arithmetic shift right), and its carry is 0.
- R5: Add sets Y to X+B and add 2x sets Y to X+2B, modulo 2^WIDTH. Each slice takes its own multiplicand bit for add and its right neighbour's bit for add 2x, with 0 below bit 0.
- R6: Subtract sets Y to X-B and subtract 2x sets Y to X-2B. Each is done as an add of the inverted operand with a carry of 1 into bit 0.
- R7: For a valid command sampled at a rising edge, `dout_valid` is 1 for exactly the next cycle, and `dout` then holds bit 0 of the new Y.
- R8: Each valid command leaves the array on `left_cmd` with `left_valid`=1 for one cycle, WIDTH cycles after it was issued, in issue order. `left_carry` is the carry out of the top bit, and is 0 for initialize and shift.
- R9: Commands issued back to back every second cycle all execute. They give the same `dout` sequence as the same commands issued with long gaps.
- R10: Inside the array each command is paired with a two-wire one-hot carry field: 2'b01 means carry 0 and 2'b10 means carry 1. This field is visible on `left_carry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcand | input | WIDTH | Multiplicand, stable while commands are in flight |
| in_valid | input | 1 | Command strobe for the least significant slice |
| in_cmd | input | 6 | One-hot command code |
| dout_valid | output | 1 | Bit leaving the least significant slice is valid |
| dout | output | 1 | Accumulator bit shifted out to the right |
| left_valid | output | 1 | Executed command leaves the most significant slice |
| left_cmd | output | 6 | One-hot code of that command |
| left_carry | output | 2 | One-hot carry out of the top bit |

## Verification
Some properties are checked on every cycle by the assertions:
- an initialize always leaves a zero sum and a zero carry code;
- a shift passes its left data bit through unchanged;
- every meta-command moving between slices keeps both one-hot fields legal;
- a malformed port code never produces an output bit.

Other behaviour only the bench's scenarios can show. That covers the arithmetic for each command word against a word-level model, back-to-back issue with several commands in flight, the order and timing of left exits, and the accumulator being left unchanged after rejected codes.

// File: rtl/fold_accum_pkg.sv
`timescale 1ns/1ps
package fold_accum_pkg;

    localparam int CMD_W = 6;

    // one-hot bit positions of the command word
    localparam int P_INIT  = 0;
    localparam int P_ADD   = 1;
    localparam int P_ADD2  = 2;
    localparam int P_SUB   = 3;
    localparam int P_SUB2  = 4;
    localparam int P_SHIFT = 5;

    typedef logic [CMD_W-1:0] cmd_t;
    typedef logic [1:0]       cry_t;

    localparam cry_t CRY_ZERO = 2'b01;
    localparam cry_t CRY_ONE  = 2'b10;

    // command bundled with its carry: eight wires in all
    typedef struct packed {
        cry_t cry;
        cmd_t cmd;
    } meta_t;

    typedef struct packed {
        logic clear;
        logic pass;
        logic arith;
        logic dbl;
        logic neg;
    } ctl_t;

    function automatic ctl_t decode_cmd(input cmd_t c);
        ctl_t r;
        r.clear = c[P_INIT];
        r.pass  = c[P_SHIFT];
        r.arith = c[P_ADD] | c[P_ADD2] | c[P_SUB] | c[P_SUB2];
        r.dbl   = c[P_ADD2] | c[P_SUB2];
        r.neg   = c[P_SUB] | c[P_SUB2];
        return r;
    endfunction

    function automatic logic meta_ok(input meta_t m);
        return $onehot(m.cmd) && $onehot(m.cry);
    endfunction

    function automatic cry_t enc_cry(input logic c);
        return c ? CRY_ONE : CRY_ZERO;
    endfunction

endpackage

// File: rtl/fold_accum_ingress.sv
`timescale 1ns/1ps
module fold_accum_ingress
    import fold_accum_pkg::*;
(
    input  cmd_t  cmd_i,
    output meta_t meta_o
);
    logic seed_one;

    // subtraction starts from a carry of 1 at the least significant slice
    always_comb begin
        seed_one    = cmd_i[P_SUB] | cmd_i[P_SUB2];
        meta_o.cmd  = cmd_i;
        meta_o.cry  = enc_cry(seed_one);
    end

endmodule

// File: rtl/fold_accum_alu.sv
`timescale 1ns/1ps
module fold_accum_alu
    import fold_accum_pkg::*;
(
    input  ctl_t  ctl,
    input  cry_t  cry_in,
    input  logic  z,
    input  logic  b_own,
    input  logic  b_right,
    output logic  sum,
    output logic  cout
);
    logic bsel;
    logic cin;

    always_comb begin
        bsel = ctl.dbl ? b_right : b_own;
        if (ctl.neg) begin
            bsel = ~bsel;
        end
        cin  = (cry_in == CRY_ONE);
        sum  = 1'b0;
        cout = 1'b0;
        if (ctl.clear) begin
            sum  = 1'b0;
            cout = 1'b0;
        end else if (ctl.pass) begin
            sum  = z;
        end else if (ctl.arith) begin
            sum  = z ^ bsel ^ cin;
            cout = (z & bsel) | (z & cin) | (bsel & cin);
        end
    end

endmodule

// File: rtl/fold_accum_slice.sv
`timescale 1ns/1ps
module fold_accum_slice
    import fold_accum_pkg::*;
#(
    parameter logic SUM_V_RST = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  meta_t cmd_in,
    input  logic  cmd_in_v,
    input  logic  z_in,
    input  logic  z_in_v,
    input  logic  b_own,
    input  logic  b_right,
    input  logic  ack_cmd,
    input  logic  ack_sum,
    output logic  fire,
    output meta_t cmd_out,
    output logic  cmd_out_v,
    output logic  sum_out,
    output logic  sum_out_v
);
    ctl_t ctl;
    logic alu_sum;
    logic alu_cout;

    always_comb begin
        ctl  = decode_cmd(cmd_in.cmd);
        fire = cmd_in_v && meta_ok(cmd_in) && (z_in_v || ctl.clear);
    end

    fold_accum_alu u_alu (
        .ctl     (ctl),
        .cry_in  (cmd_in.cry),
        .z       (z_in),
        .b_own   (b_own),
        .b_right (b_right),
        .sum     (alu_sum),
        .cout    (alu_cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_out   <= 1'b0;
            sum_out_v <= SUM_V_RST;
            cmd_out   <= '0;
            cmd_out_v <= 1'b0;
        end else if (fire) begin
            sum_out     <= alu_sum;
            sum_out_v   <= 1'b1;
            cmd_out.cmd <= cmd_in.cmd;
            cmd_out.cry <= enc_cry(alu_cout);
            cmd_out_v   <= 1'b1;
        end else begin
            if (ack_sum) begin
                sum_out_v <= 1'b0;
            end
            if (ack_cmd) begin
                cmd_out_v <= 1'b0;
            end
        end
    end

    // initialize leaves a zero sum and a zero carry code
    assert_init_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && ctl.clear) |=> (sum_out == 1'b0 && cmd_out.cry == CRY_ZERO));

    // shift forwards the left data bit untouched
    assert_shift_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && ctl.pass) |=> (sum_out == $past(z_in)));

    // a meta-command handed on keeps both one-hot fields legal
    assert_meta_code_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_out_v |-> ($onehot(cmd_out.cmd) && $onehot(cmd_out.cry)));

endmodule

// File: rtl/fold_accum_array.sv
`timescale 1ns/1ps
module fold_accum_array
    import fold_accum_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] mcand,
    input  logic             in_valid,
    input  logic [5:0]       in_cmd,
    output logic             dout_valid,
    output logic             dout,
    output logic             left_valid,
    output logic [5:0]       left_cmd,
    output logic [1:0]       left_carry
);
    localparam int LAST = WIDTH - 1;

    meta_t            chain   [WIDTH+1];
    logic             chain_v [WIDTH+1];
    logic [WIDTH-1:0] s_bit;
    logic [WIDTH-1:0] s_val;
    logic [WIDTH-1:0] fired;

    fold_accum_ingress u_ingress (
        .cmd_i  (in_cmd),
        .meta_o (chain[0])
    );
    assign chain_v[0] = in_valid;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic z_src;
        logic z_src_v;
        logic ack_c;
        logic ack_s;
        logic b_r;

        if (i == LAST) begin : g_top
            // the top slice re-reads its own bit: arithmetic shift
            assign z_src   = s_bit[i];
            assign z_src_v = 1'b1;
            assign ack_c   = 1'b1;
        end else begin : g_mid
            assign z_src   = s_bit[i+1];
            assign z_src_v = s_val[i+1];
            assign ack_c   = fired[i+1];
        end

        if (i == 0) begin : g_lsb
            assign ack_s = 1'b1;
            assign b_r   = 1'b0;
        end else begin : g_upper
            assign ack_s = fired[i-1];
            assign b_r   = mcand[i-1];
        end

        fold_accum_slice #(
            .SUM_V_RST (i != 0)
        ) u_slice (
            .clk       (clk),
            .rst       (rst),
            .cmd_in    (chain[i]),
            .cmd_in_v  (chain_v[i]),
            .z_in      (z_src),
            .z_in_v    (z_src_v),
            .b_own     (mcand[i]),
            .b_right   (b_r),
            .ack_cmd   (ack_c),
            .ack_sum   (ack_s),
            .fire      (fired[i]),
            .cmd_out   (chain[i+1]),
            .cmd_out_v (chain_v[i+1]),
            .sum_out   (s_bit[i]),
            .sum_out_v (s_val[i])
        );
    end

    assign dout       = s_bit[0];
    assign dout_valid = s_val[0];
    assign left_valid = chain_v[WIDTH];
    assign left_cmd   = chain[WIDTH].cmd;
    assign left_carry = chain[WIDTH].cry;

    // malformed port codes never produce an output bit
    assert_bad_code_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !$onehot(in_cmd)) |=> !dout_valid);

    // a legal command yields its output bit on the next cycle
    assert_dout_next_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $onehot(in_cmd)) |=> dout_valid);

    // what leaves the top is a legal command and carry code
    assert_left_code_R8: assert property (@(posedge clk) disable iff (rst)
        left_valid |-> ($onehot(left_cmd) && $onehot(left_carry)));

endmodule

// File: tb/fold_accum_array_tb.sv
`timescale 1ns/1ps
module fold_accum_array_tb;

    localparam int W = 8;
    localparam logic [5:0] K_INIT  = 6'b000001;
    localparam logic [5:0] K_ADD   = 6'b000010;
    localparam logic [5:0] K_ADD2  = 6'b000100;
    localparam logic [5:0] K_SUB   = 6'b001000;
    localparam logic [5:0] K_SUB2  = 6'b010000;
    localparam logic [5:0] K_SHIFT = 6'b100000;

    // {command, expected dout} with multiplicand 8'h05, hand-derived
    localparam logic [6:0] VEC [10] = '{
        {K_INIT,  1'b0}, {K_ADD,   1'b1}, {K_ADD2,  1'b0}, {K_SUB,   1'b1},
        {K_SUB2,  1'b0}, {K_SHIFT, 1'b1}, {K_SHIFT, 1'b1}, {K_ADD,   1'b1},
        {K_SHIFT, 1'b1}, {K_SHIFT, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] mcand;
    logic         in_valid;
    logic [5:0]   in_cmd;
    logic         dout_valid;
    logic         dout;
    logic         left_valid;
    logic [5:0]   left_cmd;
    logic [1:0]   left_carry;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] acc_m;
    logic [5:0] q_cmd [256];
    logic [1:0] q_cry [256];
    int wr = 0;
    int rd = 0;
    logic mon_on = 1'b0;

    always #10 clk = ~clk;

    fold_accum_array #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .mcand      (mcand),
        .in_valid   (in_valid),
        .in_cmd     (in_cmd),
        .dout_valid (dout_valid),
        .dout       (dout),
        .left_valid (left_valid),
        .left_cmd   (left_cmd),
        .left_carry (left_carry)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] c);
        if (c == K_INIT)  return "R3 initialize";
        if (c == K_SHIFT) return "R4 shift";
        if (c == K_ADD || c == K_ADD2) return "R5 add";
        return "R6 subtract";
    endfunction

    // word-level model: Y' = op(asr(Y), B)
    task automatic model_step(input logic [5:0] c, output logic cy);
        logic [W-1:0] x;
        logic [W-1:0] bb;
        logic [W:0]   t;
        logic         ci;
        x  = {acc_m[W-1], acc_m[W-1:1]};
        bb = (c == K_ADD2 || c == K_SUB2) ? {mcand[W-2:0], 1'b0} : mcand;
        ci = 1'b0;
        if (c == K_SUB || c == K_SUB2) begin
            bb = ~bb;
            ci = 1'b1;
        end
        t = {1'b0, x} + {1'b0, bb} + {{W{1'b0}}, ci};
        if (c == K_INIT) begin
            acc_m = '0;
            cy = 1'b0;
        end else if (c == K_SHIFT) begin
            acc_m = x;
            cy = 1'b0;
        end else begin
            acc_m = t[W-1:0];
            cy = t[W];
        end
    endtask

    task automatic issue(input logic [5:0] c, output logic got);
        logic cy;
        @(negedge clk);
        in_valid = 1'b1;
        in_cmd   = c;
        @(negedge clk);
        in_valid = 1'b0;
        in_cmd   = '0;
        model_step(c, cy);
        q_cmd[wr % 256] = c;
        q_cry[wr % 256] = cy ? 2'b10 : 2'b01;
        wr++;
        chk(dout_valid === 1'b1, "R7 dout_valid after command", 32'(dout_valid), 1);
        chk(dout === acc_m[0], tag_of(c), 32'(dout), 32'(acc_m[0]));
        got = dout;
    endtask

    task automatic issue_bad(input logic [5:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_cmd   = c;
        @(negedge clk);
        in_valid = 1'b0;
        in_cmd   = '0;
        chk(dout_valid === 1'b0, "R2 bad code gives no output", 32'(dout_valid), 0);
    endtask

    task automatic burst(input logic [W-1:0] b, input int mul, input int off, input int n);
        logic got;
        repeat (W + 2) @(negedge clk);
        mcand = b;
        issue(K_INIT, got);
        for (int k = 0; k < n; k++) begin
            issue(6'(1 << ((k * mul + off) % 6)), got);
        end
    endtask

    // left-exit monitor: order, command and carry code
    always @(negedge clk) begin
        if (mon_on && left_valid) begin
            chk(rd < wr, "R8 unexpected left exit", 32'(rd), 32'(wr));
            if (rd < wr) begin
                chk(left_cmd === q_cmd[rd % 256], "R8 left command", 32'(left_cmd), 32'(q_cmd[rd % 256]));
                chk(left_carry === q_cry[rd % 256], "R10 left carry code", 32'(left_carry), 32'(q_cry[rd % 256]));
            end
            rd++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic got;
        in_valid = 1'b0;
        in_cmd   = '0;
        mcand    = 8'h05;
        acc_m    = '0;
        repeat (3) @(negedge clk);
        chk(dout_valid === 1'b0 && left_valid === 1'b0, "R1 outputs idle in reset",
            32'({dout_valid, left_valid}), 0);
        rst = 1'b0;
        mon_on = 1'b1;
        @(negedge clk);
        chk(dout_valid === 1'b0 && left_valid === 1'b0, "R1 outputs idle after reset",
            32'({dout_valid, left_valid}), 0);

        issue(K_SHIFT, got);
        chk(got === 1'b0, "R1 accumulator starts at zero", 32'(got), 0);

        // table walk with long gaps: timing of the pulse and the left exit
        for (int k = 0; k < 10; k++) begin
            issue(VEC[k][6:1], got);
            chk(got === VEC[k][0], tag_of(VEC[k][6:1]), 32'(got), 32'(VEC[k][0]));
            @(negedge clk);
            chk(dout_valid === 1'b0, "R7 dout_valid lasts one cycle", 32'(dout_valid), 0);
            repeat (W - 2) @(negedge clk);
            chk(left_valid === 1'b1, "R8 left exit after WIDTH cycles", 32'(left_valid), 1);
        end

        // malformed codes leave the accumulator untouched
        repeat (W) @(negedge clk);
        issue(K_SUB, got);
        issue_bad(6'b000000);
        issue_bad(6'b010010);
        issue_bad(6'b111111);
        repeat (W + 1) @(negedge clk);
        chk(rd == wr, "R2 bad codes never leave the array", 32'(rd), 32'(wr));
        issue(K_SHIFT, got);
        chk(got === 1'b1, "R2 state unchanged by bad codes", 32'(got), 1);

        // back-to-back issue every second cycle
        burst(8'hA7, 5, 1, 24);
        burst(8'h80, 1, 0, 18);
        burst(8'hFF, 5, 2, 18);
        burst(8'h01, 1, 3, 12);

        repeat (W + 3) @(negedge clk);
        chk(rd == wr, "R9 every pipelined command left the array", 32'(rd), 32'(wr));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule